// File: doc/BRIEF.md
# Dual-Channel Pre-Trigger Event Capture Buffer

This block records a window of samples around an alarm event into two parallel sample memories. Each memory takes its data from a source chosen by a configuration word. The candidate sources are the supply monitor, X acceleration, Y acceleration, the auxiliary converter, temperature and the XY magnitude. While no event is pending, every valid sample goes into a circular pre-trigger region. Once that region is full, an enabled alarm is accepted as the trigger. The block then fills the rest of the memory with post-trigger samples and freezes.

After a capture, software walks the frozen window through a sample pointer. Logical sample 1 is always the oldest pre-trigger sample. A read strobe on either buffer output advances the pointer, and the pointer can also be written directly. A clear command, or any configuration write, discards the window and restarts the capture from an empty pre-trigger region.

Top module: `evcap_top`

## Requirements
- R1: After reset, cfg_q is 0x327A, done is 0, ptr_q is 1, and both buffer outputs read 0.
- R2: The configuration word holds four fields. Bits 3:0 hold the length exponent N, bits 7:4 the pre-trigger exponent M, bits 11:8 the buffer 1 source and bits 15:12 the buffer 2 source. N is clamped to the range 3..10, and the total length is L = 2^N samples.
- R3: The pre-trigger depth is P = min(2^M, L). When P equals L, an accepted trigger sets done in the same clock edge, and every stored sample is from before the trigger.
- R4: The source codes are 1 supply, 2 X, 3 Y, 4 auxiliary, 5 temperature and 8 XY magnitude. Any other code stores zero data.
- R5: Before the ring holds P samples, triggers are ignored. After that, a trigger is accepted when any alarm_in bit whose trig_en bit is set is high. A high alarm whose enable bit is clear has no effect.
- R6: After a trigger, exactly L-P further valid samples are stored and then done rises. Triggers during this post-trigger fill are ignored. Samples that arrive after done do not change the stored window.
- R7: Each output word carries the data in bits 13:0 and reads 0 in bit 15. Bit 14 is 1 only on the first post-trigger sample.
- R8: Logical sample k (1..L) is the k-th oldest stored sample, counting from the oldest sample in the pre-trigger ring. Each buffer output shows the sample at ptr_q two clock edges after ptr_q changes.
- R9: A read strobe on either buffer advances ptr_q by one. The advance from L wraps ptr_q to 1.
- R10: A pointer write with a value in 1..L loads ptr_q. A pointer write with a value outside that range leaves ptr_q unchanged. A pointer write takes priority over a read advance.
- R11: A clear or a configuration write sets done to 0 and ptr_q to 1, forces both buffer outputs to 0, and restarts the capture with an empty pre-trigger ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | All sources carry a new sample this cycle |
| src_supply | input | 14 | Supply monitor sample (code 1) |
| src_xacc | input | 14 | X acceleration sample (code 2) |
| src_yacc | input | 14 | Y acceleration sample (code 3) |
| src_aux | input | 14 | Auxiliary converter sample (code 4) |
| src_temp | input | 14 | Temperature sample (code 5) |
| src_rss | input | 14 | XY magnitude sample (code 8) |
| alarm_in | input | 2 | Alarm request lines |
| trig_en | input | 2 | Per-alarm trigger enables |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| clear | input | 1 | Clear and re-arm command |
| ptr_wr | input | 1 | Sample pointer write strobe |
| ptr_wdata | input | 11 | Sample pointer write data |
| rd_buf1 | input | 1 | Read strobe for buffer 1 output |
| rd_buf2 | input | 1 | Read strobe for buffer 2 output |
| cfg_q | output | 16 | Current configuration word |
| buf1_q | output | 16 | Buffer 1 word at the pointer |
| buf2_q | output | 16 | Buffer 2 word at the pointer |
| ptr_q | output | 11 | Sample pointer |
| done | output | 1 | Capture complete and frozen |

## Verification
The done output is due one edge after the valid sample that completes the post-trigger fill. When P equals L, it is due one edge after the accepted trigger instead. ptr_q changes one edge after a read strobe or a pointer write. The buffer words follow one edge later, because the memory read is registered.

The bench drives every strobe for one cycle, starting at a falling edge. It samples done one falling edge later. It samples the buffer words two falling edges after any pointer change, and it waits two falling edges after done before reading the first sample. The ignored triggers and the disabled alarm are checked by confirming that done stays low past the point where a wrongly accepted trigger would already have completed the capture.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

    localparam int DATA_W = 14;
    localparam int WORD_W = 16;
    localparam int CFG_W  = 16;

    typedef enum logic [3:0] {
        SRC_SUPPLY = 4'd1,
        SRC_XACC   = 4'd2,
        SRC_YACC   = 4'd3,
        SRC_AUX    = 4'd4,
        SRC_TEMP   = 4'd5,
        SRC_RSS    = 4'd8
    } src_code_e;

    typedef struct packed {
        logic [3:0] src2;
        logic [3:0] src1;
        logic [3:0] pre_exp;
        logic [3:0] len_exp;
    } cap_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h327A;

    typedef struct packed {
        logic              edge_flag;
        logic [DATA_W-1:0] data;
    } cap_word_t;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_ARMED,
        ST_POST,
        ST_DONE
    } cap_state_e;

    function automatic logic [3:0] fit_len_exp(input logic [3:0] e, input int lo, input int hi);
        int v;
        v = int'(e);
        if (v < lo) v = lo;
        if (v > hi) v = hi;
        return 4'(v);
    endfunction

    function automatic logic [3:0] fit_pre_exp(input logic [3:0] m, input logic [3:0] l);
        return (m > l) ? l : m;
    endfunction

endpackage

// File: rtl/evcap_src_mux.sv
module evcap_src_mux
    import evcap_pkg::*;
(
    input  logic [3:0]        sel,
    input  logic [DATA_W-1:0] src_supply,
    input  logic [DATA_W-1:0] src_xacc,
    input  logic [DATA_W-1:0] src_yacc,
    input  logic [DATA_W-1:0] src_aux,
    input  logic [DATA_W-1:0] src_temp,
    input  logic [DATA_W-1:0] src_rss,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        case (sel)
            SRC_SUPPLY: data = src_supply;
            SRC_XACC:   data = src_xacc;
            SRC_YACC:   data = src_yacc;
            SRC_AUX:    data = src_aux;
            SRC_TEMP:   data = src_temp;
            SRC_RSS:    data = src_rss;
            default:    data = '0;
        endcase
    end
endmodule

// File: rtl/evcap_ctrl.sv
module evcap_ctrl
    import evcap_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          sample_valid,
    input  logic          trig_hit,
    input  logic [3:0]    pexp,
    input  logic [3:0]    lexp,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          wflag,
    output logic [AW-1:0] ring_wp,
    output logic          done
);
    localparam int CW = AW + 1;

    cap_state_e    state;
    logic [AW-1:0] wp;
    logic [CW-1:0] cnt;
    logic [CW-1:0] pa;
    logic [CW-1:0] pre_n;
    logic [CW-1:0] len_n;
    logic [AW-1:0] mask;

    assign pre_n   = CW'(1) << pexp;
    assign len_n   = CW'(1) << lexp;
    assign mask    = AW'(pre_n - CW'(1));
    assign ring_wp = wp;
    assign done    = (state == ST_DONE);

    always_comb begin
        we    = 1'b0;
        waddr = wp;
        wflag = 1'b0;
        if (sample_valid) begin
            if (state == ST_FILL || state == ST_ARMED) begin
                we = 1'b1;
            end else if (state == ST_POST) begin
                we    = 1'b1;
                waddr = pa[AW-1:0];
                wflag = (pa == pre_n);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state <= ST_FILL;
            wp    <= '0;
            cnt   <= '0;
            pa    <= '0;
        end else begin
            case (state)
                ST_FILL: if (sample_valid) begin
                    wp  <= (wp + AW'(1)) & mask;
                    cnt <= cnt + CW'(1);
                    if (cnt + CW'(1) == pre_n) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (sample_valid) wp <= (wp + AW'(1)) & mask;
                    if (trig_hit) begin
                        pa    <= pre_n;
                        state <= (pre_n == len_n) ? ST_DONE : ST_POST;
                    end
                end
                ST_POST: if (sample_valid) begin
                    pa <= pa + CW'(1);
                    if (pa + CW'(1) == len_n) state <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    assert_ring_region_R5: assert property (@(posedge clk) disable iff (rst)
        (we && state != ST_POST) |-> ({1'b0, waddr} < pre_n));

    assert_fill_count_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL) |-> (cnt < pre_n));

    assert_post_region_R6: assert property (@(posedge clk) disable iff (rst)
        (we && state == ST_POST) |-> (({1'b0, waddr} >= pre_n) && ({1'b0, waddr} < len_n)));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !restart) |=> done);
endmodule

// File: rtl/evcap_rdport.sv
module evcap_rdport #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          rd_step,
    input  logic          ptr_wr,
    input  logic [AW:0]   ptr_wdata,
    input  logic [3:0]    pexp,
    input  logic [3:0]    lexp,
    input  logic [AW-1:0] ring_wp,
    output logic [AW:0]   ptr_q,
    output logic [AW-1:0] raddr
);
    localparam int CW = AW + 1;

    logic [CW-1:0] pre_n;
    logic [CW-1:0] len_n;
    logic [AW-1:0] mask;
    logic [CW-1:0] idx;
    logic          wr_ok;

    assign pre_n = CW'(1) << pexp;
    assign len_n = CW'(1) << lexp;
    assign mask  = AW'(pre_n - CW'(1));
    assign idx   = ptr_q - CW'(1);
    assign wr_ok = (ptr_wdata != '0) && (ptr_wdata <= len_n);

    always_comb begin
        if (idx < pre_n) raddr = (ring_wp + idx[AW-1:0]) & mask;
        else             raddr = idx[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || restart)          ptr_q <= CW'(1);
        else if (ptr_wr && wr_ok)    ptr_q <= ptr_wdata;
        else if (!ptr_wr && rd_step) ptr_q <= (ptr_q == len_n) ? CW'(1) : ptr_q + CW'(1);
    end

    assert_ptr_range_R9: assert property (@(posedge clk) disable iff (rst)
        (ptr_q != '0) && (ptr_q <= len_n));

    assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_step && !ptr_wr && !restart && ptr_q == len_n) |=> (ptr_q == CW'(1)));

    assert_bad_write_R10: assert property (@(posedge clk) disable iff (rst)
        (ptr_wr && !wr_ok && !restart) |=> $stable(ptr_q));
endmodule

// File: rtl/evcap_mem.sv
module evcap_mem #(
    parameter int AW = 10,
    parameter int W  = 15
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        rdata <= store[raddr];
    end
endmodule

// File: rtl/evcap_top.sv
module evcap_top
    import evcap_pkg::*;
#(
    parameter int MAX_EXP = 10,
    parameter int MIN_EXP = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_valid,
    input  logic [13:0]          src_supply,
    input  logic [13:0]          src_xacc,
    input  logic [13:0]          src_yacc,
    input  logic [13:0]          src_aux,
    input  logic [13:0]          src_temp,
    input  logic [13:0]          src_rss,
    input  logic [1:0]           alarm_in,
    input  logic [1:0]           trig_en,
    input  logic                 cfg_wr,
    input  logic [15:0]          cfg_wdata,
    input  logic                 clear,
    input  logic                 ptr_wr,
    input  logic [MAX_EXP:0]     ptr_wdata,
    input  logic                 rd_buf1,
    input  logic                 rd_buf2,
    output logic [15:0]          cfg_q,
    output logic [15:0]          buf1_q,
    output logic [15:0]          buf2_q,
    output logic [MAX_EXP:0]     ptr_q,
    output logic                 done
);
    localparam int AW    = MAX_EXP;
    localparam int ENT_W = DATA_W + 1;
    localparam int NBUF  = 2;

    cap_cfg_t      cfg_s;
    logic [3:0]    lexp;
    logic [3:0]    pexp;
    logic          restart;
    logic          trig_hit;
    logic          we;
    logic [AW-1:0] waddr;
    logic          wflag;
    logic [AW-1:0] ring_wp;
    logic [AW-1:0] raddr;
    logic [3:0]    sel     [NBUF];
    logic [DATA_W-1:0] smp [NBUF];
    cap_word_t     rd_w    [NBUF];
    logic [WORD_W-1:0] out_w [NBUF];

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= cfg_wdata;
    end

    assign cfg_s    = cfg_q;
    assign lexp     = fit_len_exp(cfg_s.len_exp, MIN_EXP, MAX_EXP);
    assign pexp     = fit_pre_exp(cfg_s.pre_exp, lexp);
    assign restart  = clear | cfg_wr;
    assign trig_hit = |(alarm_in & trig_en);
    assign sel[0]   = cfg_s.src1;
    assign sel[1]   = cfg_s.src2;

    evcap_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .restart(restart), .sample_valid(sample_valid),
        .trig_hit(trig_hit), .pexp(pexp), .lexp(lexp), .we(we), .waddr(waddr),
        .wflag(wflag), .ring_wp(ring_wp), .done(done)
    );

    evcap_rdport #(.AW(AW)) u_rdport (
        .clk(clk), .rst(rst), .restart(restart), .rd_step(rd_buf1 | rd_buf2),
        .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .pexp(pexp), .lexp(lexp),
        .ring_wp(ring_wp), .ptr_q(ptr_q), .raddr(raddr)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        cap_word_t wword;
        evcap_src_mux u_mux (
            .sel(sel[g]), .src_supply(src_supply), .src_xacc(src_xacc),
            .src_yacc(src_yacc), .src_aux(src_aux), .src_temp(src_temp),
            .src_rss(src_rss), .data(smp[g])
        );
        assign wword.edge_flag = wflag;
        assign wword.data      = smp[g];
        evcap_mem #(.AW(AW), .W(ENT_W)) u_mem (
            .clk(clk), .we(we), .waddr(waddr), .wdata(wword),
            .raddr(raddr), .rdata(rd_w[g])
        );
        assign out_w[g] = done ? {1'b0, rd_w[g]} : '0;
    end

    assign buf1_q = out_w[0];
    assign buf2_q = out_w[1];
endmodule

// File: tb/evcap_top_test.sv
module evcap_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [13:0] src_supply, src_xacc, src_yacc, src_aux, src_temp, src_rss;
    logic [1:0]  alarm_in, trig_en;
    logic        cfg_wr, clear, ptr_wr, rd_buf1, rd_buf2;
    logic [15:0] cfg_wdata;
    logic [10:0] ptr_wdata;
    logic [15:0] cfg_q, buf1_q, buf2_q;
    logic [10:0] ptr_q;
    logic        done;

    int checks = 0;
    int errors = 0;
    int s = 0;

    always #10 clk = ~clk;

    evcap_top uut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .src_supply(src_supply), .src_xacc(src_xacc), .src_yacc(src_yacc),
        .src_aux(src_aux), .src_temp(src_temp), .src_rss(src_rss),
        .alarm_in(alarm_in), .trig_en(trig_en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .clear(clear), .ptr_wr(ptr_wr),
        .ptr_wdata(ptr_wdata), .rd_buf1(rd_buf1), .rd_buf2(rd_buf2),
        .cfg_q(cfg_q), .buf1_q(buf1_q), .buf2_q(buf2_q), .ptr_q(ptr_q),
        .done(done)
    );

    function automatic logic [13:0] exp_val(input int code, input int n);
        case (code)
            1: return 14'(32'h0100 + n);
            2: return 14'(32'h0200 + n);
            3: return 14'(32'h0300 + n);
            4: return 14'(32'h0400 + n);
            5: return 14'(32'h0500 + n);
            8: return 14'(32'h0600 + n);
            default: return 14'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_word(input int code, input int n, input bit flag);
        return {1'b0, flag, exp_val(code, n)};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            src_supply = exp_val(1, s); src_xacc = exp_val(2, s);
            src_yacc   = exp_val(3, s); src_aux  = exp_val(4, s);
            src_temp   = exp_val(5, s); src_rss  = exp_val(8, s);
            sample_valid = 1'b1;
            @(negedge clk);
            s++;
        end
        sample_valid = 1'b0;
    endtask

    task automatic fire(input logic [1:0] en, input logic [1:0] al);
        trig_en = en; alarm_in = al;
        @(negedge clk);
        alarm_in = 2'b00;
    endtask

    task automatic set_cfg(input logic [15:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_step();
        rd_buf1 = 1'b1;
        @(negedge clk);
        rd_buf1 = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_ptr(input int v);
        ptr_wr = 1'b1; ptr_wdata = 11'(v);
        @(negedge clk);
        ptr_wr = 1'b0;
        @(negedge clk);
    endtask

    // walk the whole window; flagk = logical index of the first post sample (0: none)
    task automatic read_all(input string tag, input int len, input int first,
                            input int flagk, input int c1, input int c2);
        repeat (2) @(negedge clk);
        for (int k = 1; k <= len; k++) begin
            check({tag, " buf1"}, buf1_q, exp_word(c1, first + k - 1, k == flagk));
            check({tag, " buf2"}, buf2_q, exp_word(c2, first + k - 1, k == flagk));
            rd_step();
        end
        check({tag, " R9 wrap ptr"}, ptr_q, 1);
        check({tag, " R9 wrap data"}, buf1_q, exp_word(c1, first, flagk == 1));
    endtask

    task automatic t_reset();
        check("R1 cfg", cfg_q, 16'h327A);
        check("R1 done", done, 0);
        check("R1 ptr", ptr_q, 1);
        check("R1 buf1", buf1_q, 0);
        check("R1 buf2", buf2_q, 0);
    endtask

    task automatic t_basic();
        int s0;
        set_cfg(16'h5223);
        s0 = s;
        push(6);
        fire(2'b01, 2'b01);
        push(3);
        check("R6 not done early", done, 0);
        push(1);
        check("R6 done", done, 1);
        read_all("R8 R7 R4 basic", 8, s0 + 2, 5, 2, 5);
    endtask

    task automatic t_early_trig();
        int s0;
        set_cfg(16'h3223);
        s0 = s;
        push(2);
        fire(2'b01, 2'b01);
        push(2);
        fire(2'b01, 2'b10);
        push(4);
        check("R5 early/disabled trigger ignored", done, 0);
        fire(2'b10, 2'b10);
        push(4);
        check("R5 enabled alarm 1 triggers", done, 1);
        read_all("R5 window", 8, s0 + 4, 5, 2, 3);
    endtask

    task automatic t_post_ignore();
        int s0;
        set_cfg(16'h3223);
        s0 = s;
        push(4);
        fire(2'b11, 2'b01);
        push(2);
        fire(2'b11, 2'b11);
        push(1);
        check("R6 post trigger ignored", done, 0);
        push(1);
        check("R6 done after L-P", done, 1);
        push(3);
        read_all("R6 frozen", 8, s0, 5, 2, 3);
    endtask

    task automatic t_saturate();
        int s0;
        set_cfg(16'h3273);
        s0 = s;
        push(10);
        fire(2'b01, 2'b01);
        check("R3 done on trigger", done, 1);
        read_all("R3 all pre", 8, s0 + 2, 0, 2, 3);
    endtask

    task automatic t_clamp();
        int s0;
        set_cfg(16'h3211);
        s0 = s;
        push(3);
        fire(2'b01, 2'b01);
        push(5);
        check("R2 low clamp not done", done, 0);
        push(1);
        check("R2 low clamp done", done, 1);
        read_all("R2 low clamp", 8, s0 + 1, 3, 2, 3);
    endtask

    task automatic t_ptr_write();
        int s0;
        set_cfg(16'h3223);
        s0 = s;
        push(4);
        fire(2'b01, 2'b01);
        push(4);
        repeat (2) @(negedge clk);
        wr_ptr(3);
        check("R10 ptr load", ptr_q, 3);
        check("R10 data at 3", buf1_q, exp_word(2, s0 + 2, 0));
        wr_ptr(0);
        check("R10 zero ignored", ptr_q, 3);
        wr_ptr(9);
        check("R10 beyond L ignored", ptr_q, 3);
        check("R10 data held", buf2_q, exp_word(3, s0 + 2, 0));
        wr_ptr(8);
        check("R10 data at 8", buf1_q, exp_word(2, s0 + 7, 0));
        rd_buf2 = 1'b1;
        @(negedge clk);
        rd_buf2 = 1'b0;
        @(negedge clk);
        check("R9 read of buf2 wraps", ptr_q, 1);
    endtask

    task automatic t_high_clamp();
        int s0;
        set_cfg(16'h32FF);
        s0 = s;
        push(1023);
        fire(2'b01, 2'b01);
        check("R5 ring not full at 1023", done, 0);
        push(1);
        fire(2'b01, 2'b01);
        check("R2 high clamp 1024 done", done, 1);
        repeat (2) @(negedge clk);
        check("R2 high clamp first", buf1_q, exp_word(2, s0, 0));
        wr_ptr(1024);
        check("R2 high clamp last", buf1_q, exp_word(2, s0 + 1023, 0));
    endtask

    task automatic t_sources(input logic [15:0] cfgv, input int c1, input int c2);
        int s0;
        set_cfg(cfgv);
        s0 = s;
        push(8);
        fire(2'b01, 2'b01);
        repeat (2) @(negedge clk);
        check("R4 src buf1", buf1_q, exp_word(c1, s0, 0));
        check("R4 src buf2", buf2_q, exp_word(c2, s0, 0));
    endtask

    task automatic t_clear();
        check("R11 done before clear", done, 1);
        rd_step();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check("R11 done cleared", done, 0);
        check("R11 ptr cleared", ptr_q, 1);
        check("R11 buf1 zero", buf1_q, 0);
        check("R11 buf2 zero", buf2_q, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; sample_valid = 1'b0; alarm_in = 2'b00; trig_en = 2'b00;
        cfg_wr = 1'b0; cfg_wdata = '0; clear = 1'b0; ptr_wr = 1'b0; ptr_wdata = '0;
        rd_buf1 = 1'b0; rd_buf2 = 1'b0;
        src_supply = '0; src_xacc = '0; src_yacc = '0; src_aux = '0; src_temp = '0; src_rss = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_early_trig();
        t_post_ignore();
        t_saturate();
        t_clamp();
        t_ptr_write();
        t_high_clamp();
        t_sources(16'h8133, 1, 8);
        t_sources(16'h6333, 3, 0);
        t_sources(16'h0433, 4, 0);
        t_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule